// File: doc/BRIEF.md
# Sub-Quadword Insert, Mask and Byte-Zero Unit

This unit is the datapath half of a read-modify-write sequence for bytes, words and longwords kept inside 64-bit memory quadwords. It takes a first operand, a second operand and a function code. It returns one 64-bit result, captured in a register on the clock edge that follows an input strobe.

Two families of functions place a field of 1, 2, 4 or 8 bytes at a byte offset inside a 128-bit pair of quadwords. Insert functions move the truncated operand into position. Mask functions clear the bytes the field will occupy. Each family has a low form, which gives the lower quadword of the pair, and a high form, which gives the part that spills into the upper quadword. A caller handles an item that straddles two quadwords by computing both halves and ORing each one into its masked memory word. A third family clears or keeps bytes according to an 8-bit lane select, which also serves as a zero-extension of narrow values.

Top module: `bim_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `illegal` are all zero after that edge. Reset takes priority over an `in_valid` strobe in the same cycle.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. When `in_valid` is low, `result` and `illegal` keep their values. Strobes in back-to-back cycles give back-to-back results.
- R3: Encoding of `op`: when bit 4 is 0, bits 3:2 pick the class (0 insert-low, 1 insert-high, 2 mask-low, 3 mask-high) and bits 1:0 pick the size (0 byte, 1 word, 2 longword, 3 quadword). Insert-low returns `opa` truncated to the size and shifted left by 8×`opb[2:0]` bits, with bits beyond 63 discarded.
- R4: Insert-high returns the bits of that same placement that fall into bits 64..127 of the 128-bit pair. With offset 0 it returns zero.
- R5: Mask-low returns `opa` with every byte that the placed field covers in the lower quadword set to zero. All other bytes pass unchanged.
- R6: Mask-high returns `opa` with the bytes that the field covers in the upper quadword set to zero. With offset 0, `opa` passes unchanged.
- R7: `op` = 5'b10000 (zero-bytes) clears byte n of `opa` when `opb[n]` is 1, for n from 0 to 7.
- R8: `op` = 5'b10001 (keep-bytes) clears byte n of `opa` when `opb[n]` is 0. Lane selects 8'h01, 8'h03 and 8'h0F zero-extend a byte, word and longword, with no sign extension.
- R9: Insert and mask functions ignore `opb[63:3]`. The byte-lane functions ignore `opb[63:8]`.
- R10: The codes 5'b00100, 5'b01100, 5'b10010 to 5'b11111 are illegal. A strobe with one of them gives `result` zero and `illegal` 1. Every legal strobe gives `illegal` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op | input | 5 | Function code |
| opa | input | 64 | First operand (data to place or to mask) |
| opb | input | 64 | Second operand (byte offset or lane select) |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered flag for an unsupported code |

## Verification
A reset and an operand strobe can arrive in the same cycle. The bench drives `rst` and `in_valid` together with an insert whose result would be nonzero. After that edge it checks that all three outputs read zero, which shows reset wins the capture. The two halves of a straddling item are exercised as a pair at offsets 5, 6 and 7, and at offset 0, where the high forms must fall back to zero or to a pass-through.

// File: rtl/bim_pkg.sv
package bim_pkg;

    localparam int DW    = 64;
    localparam int LANES = DW / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int OP_W  = 5;
    localparam int SZ_W  = 2;

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        K_INS_LO,
        K_INS_HI,
        K_MSK_LO,
        K_MSK_HI,
        K_ZERO,
        K_KEEP,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e kind;
        size_e size;
    } dec_t;

    localparam logic [OP_W-1:0] OP_ZERO = 5'b10000;
    localparam logic [OP_W-1:0] OP_KEEP = 5'b10001;

    function automatic dec_t decode_op(input logic [OP_W-1:0] code);
        dec_t d;
        d.size = size_e'(code[SZ_W-1:0]);
        d.kind = K_BAD;
        if (!code[OP_W-1]) begin
            unique case (code[3:2])
                2'd0: d.kind = K_INS_LO;
                2'd1: d.kind = K_INS_HI;
                2'd2: d.kind = K_MSK_LO;
                default: d.kind = K_MSK_HI;
            endcase
            if ((d.kind == K_INS_HI || d.kind == K_MSK_HI) && d.size == SZ_BYTE)
                d.kind = K_BAD;
        end else if (code == OP_ZERO) begin
            d.kind = K_ZERO;
        end else if (code == OP_KEEP) begin
            d.kind = K_KEEP;
        end
        return d;
    endfunction

    function automatic logic [LANES-1:0] size_lanes(input size_e sz);
        logic [LANES-1:0] l;
        for (int i = 0; i < LANES; i++)
            l[i] = (i < (1 << sz));
        return l;
    endfunction

    function automatic logic [DW-1:0] lanes_to_bits(input logic [LANES-1:0] l);
        logic [DW-1:0] m;
        for (int i = 0; i < LANES; i++)
            m[i*8 +: 8] = {8{l[i]}};
        return m;
    endfunction

endpackage

// File: rtl/bim_lane_gen.sv
module bim_lane_gen
    import bim_pkg::*;
#(
    parameter int NL = LANES,
    localparam int OW = $clog2(NL)
) (
    input  logic [NL-1:0] field,
    input  logic [OW-1:0] off,
    output logic [NL-1:0] lane_lo,
    output logic [NL-1:0] lane_hi
);
    logic [2*NL-1:0] pair;

    always_comb begin
        pair    = {{NL{1'b0}}, field} << off;
        lane_lo = pair[NL-1:0];
        lane_hi = pair[2*NL-1:NL];
    end
endmodule

// File: rtl/bim_place.sv
module bim_place
    import bim_pkg::*;
#(
    parameter int W = DW,
    localparam int NL = W / 8,
    localparam int OW = $clog2(NL)
) (
    input  logic [W-1:0]  data,
    input  logic [NL-1:0] field,
    input  logic [OW-1:0] off,
    output logic [W-1:0]  data_lo,
    output logic [W-1:0]  data_hi
);
    logic [W-1:0]   trunc;
    logic [2*W-1:0] pair;
    logic [OW+2:0]  shamt;

    always_comb begin
        trunc = '0;
        for (int i = 0; i < NL; i++)
            trunc[i*8 +: 8] = field[i] ? data[i*8 +: 8] : 8'h00;
        shamt   = {off, 3'b000};
        pair    = {{W{1'b0}}, trunc} << shamt;
        data_lo = pair[W-1:0];
        data_hi = pair[2*W-1:W];
    end
endmodule

// File: rtl/bim_byte_gate.sv
module bim_byte_gate
    import bim_pkg::*;
#(
    parameter int W = DW,
    localparam int NL = W / 8
) (
    input  logic [W-1:0]  din,
    input  logic [NL-1:0] keep,
    output logic [W-1:0]  dout
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign dout[g*8 +: 8] = keep[g] ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/bim_unit.sv
module bim_unit
    import bim_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic            out_valid,
    output logic [DW-1:0]   result,
    output logic            illegal
);
    dec_t             dec;
    logic [LANES-1:0] field;
    logic [OFF_W-1:0] off;
    logic [LANES-1:0] lane_lo;
    logic [LANES-1:0] lane_hi;
    logic [DW-1:0]    ins_lo;
    logic [DW-1:0]    ins_hi;
    logic [LANES-1:0] keep_sel;
    logic [DW-1:0]    gated;
    logic [DW-1:0]    nxt_res;
    logic             nxt_bad;
    logic             unused_opb;

    assign unused_opb = ^opb[DW-1:LANES];

    always_comb begin
        dec   = decode_op(op);
        field = size_lanes(dec.size);
        off   = opb[OFF_W-1:0];
    end

    bim_lane_gen #(.NL(LANES)) u_lanes (
        .field   (field),
        .off     (off),
        .lane_lo (lane_lo),
        .lane_hi (lane_hi)
    );

    bim_place #(.W(DW)) u_place (
        .data    (opa),
        .field   (field),
        .off     (off),
        .data_lo (ins_lo),
        .data_hi (ins_hi)
    );

    always_comb begin
        unique case (dec.kind)
            K_MSK_LO: keep_sel = ~lane_lo;
            K_MSK_HI: keep_sel = ~lane_hi;
            K_ZERO:   keep_sel = ~opb[LANES-1:0];
            K_KEEP:   keep_sel = opb[LANES-1:0];
            default:  keep_sel = '1;
        endcase
    end

    bim_byte_gate #(.W(DW)) u_gate (
        .din  (opa),
        .keep (keep_sel),
        .dout (gated)
    );

    always_comb begin
        nxt_bad = 1'b0;
        unique case (dec.kind)
            K_INS_LO: nxt_res = ins_lo;
            K_INS_HI: nxt_res = ins_hi;
            K_MSK_LO, K_MSK_HI, K_ZERO, K_KEEP: nxt_res = gated;
            default: begin
                nxt_res = '0;
                nxt_bad = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= nxt_res;
                illegal <= nxt_bad;
            end
        end
    end
endmodule

// File: rtl/bim_unit_chk.sv
module bim_unit_chk
    import bim_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [OP_W-1:0] op,
    input logic [DW-1:0]   opa,
    input logic [DW-1:0]   opb,
    input logic            out_valid,
    input logic [DW-1:0]   result,
    input logic            illegal
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !illegal));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));

    a_r10_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        illegal |-> result == '0);

    a_r4_ins_hi_off0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[4:2] == 3'b001 && op[1:0] != 2'b00 && opb[2:0] == 3'd0)
        |=> result == '0);

    a_r6_msk_hi_off0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[4:2] == 3'b011 && op[1:0] != 2'b00 && opb[2:0] == 3'd0)
        |=> result == $past(opa));

    a_r7_zero_all: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_ZERO && opb[7:0] == 8'hFF) |=> result == '0);
endmodule

bind bim_unit bim_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/bim_unit_bench.sv
module bim_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bim_unit u_bim_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .out_valid(out_valid),
        .result(result), .illegal(illegal)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [4:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
    } vec_t;

    localparam logic [63:0] D = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] A = 64'h8877_6655_4433_2211;
    localparam int NV = 27;

    localparam vec_t TBL [NV] = '{
        '{"R3", 5'b00000, D, 64'd3, 64'h0000_0000_1000_0000, 1'b0},
        '{"R3", 5'b00001, D, 64'd5, 64'h0032_1000_0000_0000, 1'b0},
        '{"R3", 5'b00010, D, 64'd6, 64'h3210_0000_0000_0000, 1'b0},
        '{"R3", 5'b00011, D, 64'd1, 64'hDCBA_9876_5432_1000, 1'b0},
        '{"R4", 5'b00101, D, 64'd7, 64'h0000_0000_0000_0032, 1'b0},
        '{"R4", 5'b00110, D, 64'd6, 64'h0000_0000_0000_7654, 1'b0},
        '{"R4", 5'b00111, D, 64'd3, 64'h0000_0000_00FE_DCBA, 1'b0},
        '{"R4", 5'b00111, D, 64'd0, 64'h0000_0000_0000_0000, 1'b0},
        '{"R5", 5'b01000, A, 64'd2, 64'h8877_6655_4400_2211, 1'b0},
        '{"R5", 5'b01001, A, 64'd7, 64'h0077_6655_4433_2211, 1'b0},
        '{"R5", 5'b01010, A, 64'd2, 64'h8877_0000_0000_2211, 1'b0},
        '{"R5", 5'b01011, A, 64'd3, 64'h0000_0000_0033_2211, 1'b0},
        '{"R6", 5'b01101, A, 64'd7, 64'h8877_6655_4433_2200, 1'b0},
        '{"R6", 5'b01110, A, 64'd6, 64'h8877_6655_4433_0000, 1'b0},
        '{"R6", 5'b01111, A, 64'd0, A,                       1'b0},
        '{"R6", 5'b01111, A, 64'd5, 64'h8877_6600_0000_0000, 1'b0},
        '{"R7", 5'b10000, A, 64'h81, 64'h0077_6655_4433_2200, 1'b0},
        '{"R7", 5'b10000, A, 64'hFF, 64'h0000_0000_0000_0000, 1'b0},
        '{"R8", 5'b10001, 64'h1234_5678_9ABC_DEF0, 64'h0F, 64'h0000_0000_9ABC_DEF0, 1'b0},
        '{"R8", 5'b10001, A, 64'h01, 64'h0000_0000_0000_0011, 1'b0},
        '{"R8", 5'b10001, A, 64'h03, 64'h0000_0000_0000_2211, 1'b0},
        '{"R9", 5'b00000, D, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_0010, 1'b0},
        '{"R9", 5'b10000, A, 64'hFFFF_FFFF_FFFF_FF00, A, 1'b0},
        '{"R9", 5'b01101, A, 64'hAAAA_0000_0000_0007, 64'h8877_6655_4433_2200, 1'b0},
        '{"R10", 5'b00100, D, 64'd3, 64'h0, 1'b1},
        '{"R10", 5'b01100, A, 64'd1, 64'h0, 1'b1},
        '{"R10", 5'b11111, A, 64'd0, 64'h0, 1'b1}
    };

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic strobe(input logic [4:0] c, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = c; opa = a; opb = b;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", {63'b0, out_valid}, 64'd0);
        chk("R1", "result", result, 64'd0);
        chk("R1", "illegal", {63'b0, illegal}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            strobe(TBL[i].op, TBL[i].a, TBL[i].b);
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("%s", TBL[i].tag), "result", result, TBL[i].exp);
            chk($sformatf("%s", TBL[i].tag), "illegal", {63'b0, illegal}, {63'b0, TBL[i].ill});
            chk("R2", "out_valid after strobe", {63'b0, out_valid}, 64'd1);
        end

        // R2: idle cycle keeps result, drops out_valid
        held = result;
        opa = 64'hFFFF_FFFF_FFFF_FFFF; op = 5'b00011;
        @(negedge clk);
        chk("R2", "out_valid idle", {63'b0, out_valid}, 64'd0);
        chk("R2", "result held", result, held);
        chk("R2", "illegal held", {63'b0, illegal}, 64'd1);

        // R2: back-to-back strobes
        strobe(5'b00011, D, 64'd0);
        strobe(5'b01010, A, 64'd4);
        chk("R2", "first of pair", result, D);
        chk("R2", "illegal cleared", {63'b0, illegal}, 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5", "second of pair", result, 64'h0000_0000_4433_2211);
        chk("R2", "out_valid pair", {63'b0, out_valid}, 64'd1);

        // R1: reset and strobe in the same cycle, reset wins
        strobe(5'b00011, D, 64'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        chk("R1", "collide result", result, 64'd0);
        chk("R1", "collide out_valid", {63'b0, out_valid}, 64'd0);

        // R3/R4: straddling long at offset 5 as a low/high pair
        strobe(5'b00010, D, 64'd5);
        strobe(5'b00110, D, 64'd5);
        chk("R3", "straddle low", result, 64'h5432_1000_0000_0000);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4", "straddle high", result, 64'h0000_0000_0000_0076);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule